// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port shared memory and settles which port may use a location when both ports point at it at once. Each port presents a chip enable, a write request and an address. In master mode the block decides the winner and pulls the active-low busy line of the losing port. In slave mode it makes no decision of its own: it takes each port's busy line from an external master and uses it to stop writes, so several devices can be stacked to widen the data word.

Arrival order is judged by clock cycle. A port "starts" an access in the cycle where its enable rises, or where its address changes while its enable is already high. The port whose start came in an earlier cycle wins. When both start in the same cycle, a parameter picks the winner, and by default the left port wins. The grant then holds for as long as the two addresses stay equal with both enables high. The arbiter is a four-state machine: `ST_SLAVE` (slave mode, no arbitration), `ST_OPEN` (master mode, no contention), `ST_LEFT_HOLD` (left owns the location, right is busy) and `ST_RIGHT_HOLD` (right owns, left is busy). Transitions are `to_slave` (select low, from any state), `claim` (a match is seen from `ST_OPEN`/`ST_SLAVE`, going to the hold state the arrival rule picks), `rearbitrate` (the owner starts a fresh access while a match remains), `release` (the match ends, back to `ST_OPEN`) and `keep` (the match stays and the owner has not restarted).

Top module: `dpa_contention_arb`

## Requirements
- R1: A busy output goes low only in the cycle after both enables were high with equal addresses. It never goes low otherwise.
- R2: The two busy outputs are never low together. In master mode, a match seen at a clock edge leaves exactly one of them low after that edge.
- R3: Busy to the losing port goes low one cycle after the match appears. This holds when the match comes from an address change and when it comes from an enable rising onto an address that already matches.
- R4: A port starts an access when its enable rises, or when its address changes while enabled. The port whose last start came in an earlier cycle wins, so the other port sees busy.
- R5: When both ports start in the same cycle, the left port wins with the default TIE_LEFT=1.
- R6: Once a port has won, it keeps the grant while the match lasts and it does not restart, whatever the loser's write request does.
- R7: Both busy outputs return high one cycle after the match ends, whether the winner drops its enable or moves to another address.
- R8: With ms_sel high (master), the busy outputs report the arbitration result. With ms_sel low (slave), both busy outputs are high from the cycle after ms_sel is seen low.
- R9: Write permit for a port is enable AND write AND busy-high, computed combinationally. The busy used is the busy input in slave mode and the block's own busy output in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_sel | input | 1 | 1 = master (arbitrate), 0 = slave (obey busy inputs) |
| l_en | input | 1 | Left port chip enable, active high |
| l_wr | input | 1 | Left port write request |
| l_addr | input | AW | Left port address |
| l_busy_in_n | input | 1 | Busy from an external master to the left port (slave mode) |
| l_busy_out_n | output | 1 | Busy to the left port, active low (master mode) |
| l_wr_ok | output | 1 | Left write may reach the memory |
| r_en | input | 1 | Right port chip enable, active high |
| r_wr | input | 1 | Right port write request |
| r_addr | input | AW | Right port address |
| r_busy_in_n | input | 1 | Busy from an external master to the right port (slave mode) |
| r_busy_out_n | output | 1 | Busy to the right port, active low (master mode) |
| r_wr_ok | output | 1 | Right write may reach the memory |

## Verification
The properties assume every input is a clean synchronous level that changes once per clock, away from the edge. They also assume the decision for an edge depends only on the values sampled at that edge, so a match is judged one full cycle before busy reacts. The bench drives all inputs just after a rising edge and samples just after the next one. It sweeps every address pair of a 2-bit configuration under the three arrival orders, then every slave-mode combination of enable, write and busy input. Mode changes are made only while both ports are idle, so the hold properties never see a mode switch in the middle of a match.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [1:0] {
        ST_SLAVE      = 2'd0,
        ST_OPEN       = 2'd1,
        ST_LEFT_HOLD  = 2'd2,
        ST_RIGHT_HOLD = 2'd3
    } arb_state_e;

    localparam int unsigned PORT_LEFT  = 0;
    localparam int unsigned PORT_RIGHT = 1;
    localparam int unsigned NUM_PORTS  = 2;

endpackage

// File: rtl/dpa_access_track.sv
// Flags the cycle in which a port starts a new access.
module dpa_access_track #(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic          fresh
);

    logic          en_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    // A start is an enable edge or an address move under enable.
    always_comb begin
        fresh = en && (!en_q || (addr != addr_q));
    end

endmodule

// File: rtl/dpa_arb_fsm.sv
module dpa_arb_fsm
    import dpa_pkg::*;
#(
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master,
    input  logic       match,
    input  logic       l_fresh,
    input  logic       r_fresh,
    output arb_state_e state,
    output logic       l_busy_n,
    output logic       r_busy_n
);

    arb_state_e state_q;
    arb_state_e state_d;
    arb_state_e tie_pick;
    arb_state_e decided;

    // The tie winner is fixed when the design is built.
    generate
        if (TIE_LEFT) begin : g_tie_left
            assign tie_pick = ST_LEFT_HOLD;
        end else begin : g_tie_right
            assign tie_pick = ST_RIGHT_HOLD;
        end
    endgenerate

    // Arrival rule: the port that did not restart this cycle came first.
    always_comb begin
        if (l_fresh && !r_fresh) begin
            decided = ST_RIGHT_HOLD;
        end else if (r_fresh && !l_fresh) begin
            decided = ST_LEFT_HOLD;
        end else begin
            decided = tie_pick;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!master) begin
            state_d = ST_SLAVE;                       // to_slave
        end else begin
            unique case (state_q)
                ST_SLAVE, ST_OPEN: begin
                    state_d = match ? decided : ST_OPEN;  // claim
                end
                ST_LEFT_HOLD: begin
                    if (!match) begin
                        state_d = ST_OPEN;            // release
                    end else if (l_fresh) begin
                        state_d = decided;            // rearbitrate
                    end else begin
                        state_d = ST_LEFT_HOLD;       // keep
                    end
                end
                ST_RIGHT_HOLD: begin
                    if (!match) begin
                        state_d = ST_OPEN;            // release
                    end else if (r_fresh) begin
                        state_d = decided;            // rearbitrate
                    end else begin
                        state_d = ST_RIGHT_HOLD;      // keep
                    end
                end
                default: state_d = ST_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state    = state_q;
        l_busy_n = 1'b1;
        r_busy_n = 1'b1;
        unique case (state_q)
            ST_LEFT_HOLD:  r_busy_n = 1'b0;
            ST_RIGHT_HOLD: l_busy_n = 1'b0;
            ST_SLAVE, ST_OPEN: begin
                l_busy_n = 1'b1;
                r_busy_n = 1'b1;
            end
            default: begin
                l_busy_n = 1'b1;
                r_busy_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dpa_write_gate.sv
// Lets a write through only when the port is not held off.
module dpa_write_gate (
    input  logic master,
    input  logic en,
    input  logic wr,
    input  logic own_busy_n,
    input  logic ext_busy_n,
    output logic wr_ok
);

    logic busy_eff_n;

    always_comb begin
        busy_eff_n = master ? own_busy_n : ext_busy_n;
        wr_ok      = en && wr && busy_eff_n;
    end

endmodule

// File: rtl/dpa_contention_arb.sv
module dpa_contention_arb
    import dpa_pkg::*;
#(
    parameter int unsigned AW       = 4,
    parameter bit          TIE_LEFT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_sel,
    input  logic          l_en,
    input  logic          l_wr,
    input  logic [AW-1:0] l_addr,
    input  logic          l_busy_in_n,
    output logic          l_busy_out_n,
    output logic          l_wr_ok,
    input  logic          r_en,
    input  logic          r_wr,
    input  logic [AW-1:0] r_addr,
    input  logic          r_busy_in_n,
    output logic          r_busy_out_n,
    output logic          r_wr_ok
);

    logic [NUM_PORTS-1:0] en_v;
    logic [NUM_PORTS-1:0] wr_v;
    logic [NUM_PORTS-1:0] ext_busy_v;
    logic [NUM_PORTS-1:0] own_busy_v;
    logic [NUM_PORTS-1:0] fresh_v;
    logic [NUM_PORTS-1:0] wr_ok_v;
    logic [AW-1:0]        addr_v [NUM_PORTS];
    logic                 match;
    arb_state_e           state;

    assign en_v[PORT_LEFT]        = l_en;
    assign en_v[PORT_RIGHT]       = r_en;
    assign wr_v[PORT_LEFT]        = l_wr;
    assign wr_v[PORT_RIGHT]       = r_wr;
    assign ext_busy_v[PORT_LEFT]  = l_busy_in_n;
    assign ext_busy_v[PORT_RIGHT] = r_busy_in_n;
    assign addr_v[PORT_LEFT]      = l_addr;
    assign addr_v[PORT_RIGHT]     = r_addr;

    assign match = en_v[PORT_LEFT] && en_v[PORT_RIGHT] &&
                   (addr_v[PORT_LEFT] == addr_v[PORT_RIGHT]);

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
            dpa_access_track #(.AW(AW)) u_track (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en_v[g]),
                .addr  (addr_v[g]),
                .fresh (fresh_v[g])
            );
            dpa_write_gate u_gate (
                .master     (ms_sel),
                .en         (en_v[g]),
                .wr         (wr_v[g]),
                .own_busy_n (own_busy_v[g]),
                .ext_busy_n (ext_busy_v[g]),
                .wr_ok      (wr_ok_v[g])
            );
        end
    endgenerate

    dpa_arb_fsm #(.TIE_LEFT(TIE_LEFT)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .master   (ms_sel),
        .match    (match),
        .l_fresh  (fresh_v[PORT_LEFT]),
        .r_fresh  (fresh_v[PORT_RIGHT]),
        .state    (state),
        .l_busy_n (own_busy_v[PORT_LEFT]),
        .r_busy_n (own_busy_v[PORT_RIGHT])
    );

    assign l_busy_out_n = own_busy_v[PORT_LEFT];
    assign r_busy_out_n = own_busy_v[PORT_RIGHT];
    assign l_wr_ok      = wr_ok_v[PORT_LEFT];
    assign r_wr_ok      = wr_ok_v[PORT_RIGHT];

endmodule

// File: rtl/dpa_contention_chk.sv
module dpa_contention_chk #(
    parameter int unsigned AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ms_sel,
    input logic          l_en,
    input logic [AW-1:0] l_addr,
    input logic          l_busy_in_n,
    input logic          l_busy_out_n,
    input logic          l_wr_ok,
    input logic          r_en,
    input logic [AW-1:0] r_addr,
    input logic          r_busy_in_n,
    input logic          r_busy_out_n,
    input logic          r_wr_ok
);

    logic hit;
    assign hit = l_en && r_en && (l_addr == r_addr);

    assert_never_both_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_out_n && !r_busy_out_n));

    assert_match_gives_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_sel && hit) |=> (!l_busy_out_n || !r_busy_out_n));

    assert_busy_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_out_n || !r_busy_out_n) |-> $past(hit));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_sel && !hit) |=> (l_busy_out_n && r_busy_out_n));

    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_sel |=> (l_busy_out_n && r_busy_out_n));

    assert_hold_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_sel && !r_busy_out_n && hit && $past(l_en) && $stable(l_addr))
        |=> !r_busy_out_n);

    assert_hold_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_sel && !l_busy_out_n && hit && $past(r_en) && $stable(r_addr))
        |=> !l_busy_out_n);

    assert_slave_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_sel && (!l_busy_in_n || !r_busy_in_n)) |->
        ((l_busy_in_n || !l_wr_ok) && (r_busy_in_n || !r_wr_ok)));

endmodule

bind dpa_contention_arb dpa_contention_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_sel       (ms_sel),
    .l_en         (l_en),
    .l_addr       (l_addr),
    .l_busy_in_n  (l_busy_in_n),
    .l_busy_out_n (l_busy_out_n),
    .l_wr_ok      (l_wr_ok),
    .r_en         (r_en),
    .r_addr       (r_addr),
    .r_busy_in_n  (r_busy_in_n),
    .r_busy_out_n (r_busy_out_n),
    .r_wr_ok      (r_wr_ok)
);

// File: tb/tb_dpa_contention_arb.sv
module tb_dpa_contention_arb;

    localparam int unsigned AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_sel = 1'b1;
    logic          l_en = 1'b0, l_wr = 1'b0, l_busy_in_n = 1'b1;
    logic          r_en = 1'b0, r_wr = 1'b0, r_busy_in_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_out_n, r_busy_out_n, l_wr_ok, r_wr_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dpa_contention_arb #(.AW(AW), .TIE_LEFT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .ms_sel(ms_sel),
        .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr), .l_busy_in_n(l_busy_in_n),
        .l_busy_out_n(l_busy_out_n), .l_wr_ok(l_wr_ok),
        .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr), .r_busy_in_n(r_busy_in_n),
        .r_busy_out_n(r_busy_out_n), .r_wr_ok(r_wr_ok)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        tick();
        tick();
        check("R1 reset left busy", l_busy_out_n, 1'b1);
        check("R1 reset right busy", r_busy_out_n, 1'b1);
        rst_n = 1'b1;
        tick();

        // Master sweep: every address pair, three arrival orders.
        for (int la = 0; la < 4; la++) begin
            for (int ra = 0; ra < 4; ra++) begin
                for (int ord = 0; ord < 3; ord++) begin
                    bit m;
                    bit left_wins;
                    l_en = 0; r_en = 0; l_wr = 0; r_wr = 0;
                    tick();
                    l_addr = la[AW-1:0];
                    r_addr = ra[AW-1:0];
                    if (ord == 0) begin
                        l_en = 1; tick(); r_en = 1;
                    end else if (ord == 1) begin
                        r_en = 1; tick(); l_en = 1;
                    end else begin
                        l_en = 1; r_en = 1;
                    end
                    tick();
                    m = (la == ra);
                    left_wins = (ord != 1);   // R4 earlier wins, R5 tie to left
                    check($sformatf("R3/R4/R5 left busy la=%0d ra=%0d ord=%0d", la, ra, ord),
                          l_busy_out_n, !(m && !left_wins));
                    check($sformatf("R1/R2 right busy la=%0d ra=%0d ord=%0d", la, ra, ord),
                          r_busy_out_n, !(m && left_wins));
                    l_wr = 1; r_wr = 1;
                    #1;
                    check("R9 master left write", l_wr_ok, !(m && !left_wins));
                    check("R9 master right write", r_wr_ok, !(m && left_wins));
                    if (left_wins) l_en = 0; else r_en = 0;
                    tick();
                    check("R7 release left", l_busy_out_n, 1'b1);
                    check("R7 release right", r_busy_out_n, 1'b1);
                end
            end
        end

        // Match created by an address move while both are enabled.
        l_en = 1; r_en = 1; l_wr = 0; r_wr = 0;
        l_addr = 2'd0; r_addr = 2'd1;
        tick(); tick();
        r_addr = 2'd0;
        tick();
        check("R3 addr move right loses", r_busy_out_n, 1'b0);
        check("R3 addr move left free", l_busy_out_n, 1'b1);
        for (int k = 0; k < 4; k++) begin
            r_wr = k[0];
            tick();
            check("R6 grant kept", r_busy_out_n, 1'b0);
            check("R6 loser write blocked", r_wr_ok, 1'b0);
        end
        l_addr = 2'd3;
        tick();
        check("R7 winner moves away", r_busy_out_n, 1'b1);
        l_addr = 2'd0;          // left restarts onto right's address
        tick();
        check("R4 late left busy", l_busy_out_n, 1'b0);
        check("R4 early right free", r_busy_out_n, 1'b1);
        l_en = 0; r_en = 0; r_wr = 0;
        tick();

        // Slave sweep: all enable/write/busy-in combinations.
        ms_sel = 0;
        tick(); tick();
        for (int v = 0; v < 64; v++) begin
            l_en = v[0]; l_wr = v[1]; l_busy_in_n = v[2];
            r_en = v[3]; r_wr = v[4]; r_busy_in_n = v[5];
            l_addr = 2'd1; r_addr = 2'd1;
            tick();
            check("R8 slave left busy out high", l_busy_out_n, 1'b1);
            check("R8 slave right busy out high", r_busy_out_n, 1'b1);
            check($sformatf("R9 slave left write v=%0d", v), l_wr_ok, v[0] & v[1] & v[2]);
            check($sformatf("R9 slave right write v=%0d", v), r_wr_ok, v[3] & v[4] & v[5]);
        end
        l_en = 0; r_en = 0; l_busy_in_n = 1; r_busy_in_n = 1;
        tick();
        ms_sel = 1;
        tick();
        l_en = 1; r_en = 1;
        tick();
        check("R8 master again right busy", r_busy_out_n, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule